// File: doc/BRIEF.md
# SRAM Snooze Power-Down Controller

This block governs the sleep state of a synchronous burst SRAM core. One sleep request pin, asynchronous and active high, puts the memory to sleep. While the request is high, the core is deselected, the host input paths are gated off and the data outputs are held at high impedance. These three effects follow the raw pin with no clock delay. A two-flop synchronized copy of the request drives a small state machine. The machine counts a parameterized entry delay before it reports that the low-current condition has been reached. After the request falls, it opens a parameterized power-up window during which it checks each host command.

The block has a host command code input. It reports two kinds of misuse with one-cycle error pulses. The first is a read or a write offered in the cycle in which the synchronized request is first seen. The second is any command other than deselect or read offered while the power-up window is open. The block never touches the memory array, so stored data is left as it was. A new request during the power-up window aborts the exit and restarts the entry delay.

Top module: `sram_snooze_ctrl`

## Requirements
- R1: The active-low synchronous reset clears the state to awake: `low_current`, `exit_window`, `entry_err` and `wake_err` read 0 after a reset edge, even if `sleep_req` is high, and the block stays awake afterwards while the request is low.
- R2: `outputs_hiz` equals `sleep_req` and `inputs_enable` equals its inverse, combinationally, with no clock edge needed.
- R3: `core_deselect` is high whenever `sleep_req` is high. It is also high while the controller is entering or in sleep. With the request rising just after edge 0 and falling just after edge h, this means `sleep_req` OR (3 <= t <= h+2) after edge t.
- R4: With `sleep_req` rising just after edge 0, `low_current` first reads 1 after edge ENTRY_CYC+3. This counts two synchronizer stages, one state register edge and ENTRY_CYC cycles of entry delay.
- R5: Sleep lasts exactly as long as the request stays high. If the request falls just after edge h, `low_current` reads 0 from edge h+3 onward, and it is 1 after edge t only for ENTRY_CYC+3 <= t <= h+2.
- R6: After the request falls just after edge h, `exit_window` reads 1 after edges h+3 through h+2+EXIT_CYC, and 0 outside that range. It is never high together with `low_current`.
- R7: Command codes on `host_cmd` are 0 deselect, 1 read, 2 write and 3 reserved. A code of 2 or 3 held in a cycle while `exit_window` is 1 makes `wake_err` read 1 for one cycle after the next edge. Codes 0 and 1 never raise it.
- R8: A nonzero `host_cmd` in the cycle in which the synchronized request is first high and the state is still awake makes `entry_err` read 1 for one cycle after the next edge. With the request rising just after edge 0, this is the command held between edges 2 and 3, and the pulse reads 1 after edge 3. Commands in any other cycle do not raise it.
- R9: If the synchronized request is high while the exit window is open, the exit is aborted: `exit_window` drops at the next edge, and `low_current` returns only after a full ENTRY_CYC entry delay counted from that edge.
- R10: If the request falls before the entry delay completes, `low_current` never asserts. The exit window still opens for EXIT_CYC cycles, with the timing of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| host_cmd | input | 2 | Host command code: 0 deselect, 1 read, 2 write, 3 reserved |
| core_deselect | output | 1 | Forces the SRAM core deselected |
| inputs_enable | output | 1 | High when host inputs may reach the core |
| outputs_hiz | output | 1 | High when data outputs must float |
| low_current | output | 1 | Entry delay elapsed; the core is in low-current sleep |
| exit_window | output | 1 | Power-up window open; only deselect or read allowed |
| entry_err | output | 1 | One-cycle pulse: read or write offered at sleep entry |
| wake_err | output | 1 | One-cycle pulse: illegal command during the power-up window |

## Verification
The assertions assume that `sleep_req` holds each level for at least one full clock period, so that the synchronizer never misses an edge and the raw pin and its synchronized copy agree within two cycles. They also assume that `host_cmd` is stable around each clock edge. The bench changes the request and the command only a fixed delay after a rising edge and keeps every high or low phase of the request at one cycle or longer. Each scenario begins from a known awake state with several idle cycles between runs, so the edge counts in the requirements apply from a clean start.

// File: rtl/snz_pkg.sv
// Shared types of the snooze controller: host command codes and controller states.
package snz_pkg;
    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_ENTER = 2'd1,
        ST_SLEEP = 2'd2,
        ST_EXIT  = 2'd3
    } state_e;
endpackage

// File: rtl/snz_sync.sv
// Multi-stage level synchronizer for the asynchronous sleep request.
// Assumes STAGES >= 2 and that the input holds each level for at least one clock.
module snz_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain; reset clears it to "awake".
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/snz_cnt.sv
// Saturating cycle counter with a synchronous clear, shared by the entry and exit delays.
// Assumes the owner clears it on every state change.
module snz_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] q
);
    // Count up while not cleared, holding at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  q <= '0;
        else if (q != '1)   q <= q + W'(1);
    end
endmodule

// File: rtl/snz_fsm.sv
// Sleep state machine: it walks awake -> enter -> sleep -> exit on the synchronized
// request and flags illegal commands at entry and in the power-up window.
// Assumes ENTRY_CYC >= 1, EXIT_CYC >= 1, and a counter that is zero after each clear.
module snz_fsm #(
    parameter int ENTRY_CYC = 8,
    parameter int EXIT_CYC  = 8,
    parameter int CW        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_s,
    input  logic [1:0]       cmd,
    input  logic [CW-1:0]    cnt,
    output logic             cnt_clr,
    output snz_pkg::state_e  state,
    output logic             entry_err,
    output logic             wake_err
);
    import snz_pkg::*;

    localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);

    state_e nxt;

    // Next-state choice; an abort during the exit window takes priority over completion.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_AWAKE: if (req_s) nxt = ST_ENTER;
            ST_ENTER: if (!req_s) nxt = ST_EXIT;
                      else if (cnt == ENTRY_LAST) nxt = ST_SLEEP;
            ST_SLEEP: if (!req_s) nxt = ST_EXIT;
            ST_EXIT:  if (req_s) nxt = ST_ENTER;
                      else if (cnt == EXIT_LAST) nxt = ST_AWAKE;
            default:  nxt = ST_AWAKE;
        endcase
    end

    // Restart the delay count on every transition and while waiting on the request.
    assign cnt_clr = (nxt != state) || (state == ST_AWAKE) || (state == ST_SLEEP);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= nxt;
    end

    // One-cycle error pulses for commands offered at entry or during power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_err <= 1'b0;
            wake_err  <= 1'b0;
        end else begin
            entry_err <= (state == ST_AWAKE) && req_s && (cmd != CMD_DESEL);
            wake_err  <= (state == ST_EXIT) && (cmd != CMD_DESEL) && (cmd != CMD_READ);
        end
    end
endmodule

// File: rtl/sram_snooze_ctrl.sv
// Snooze controller top: the raw request gates inputs and floats outputs at once,
// and a synchronized copy drives the timed entry and exit sequence.
// Assumes sleep_req holds each level for at least one clock period.
module sram_snooze_ctrl #(
    parameter int ENTRY_CYC   = 8,
    parameter int EXIT_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic [1:0] host_cmd,
    output logic       core_deselect,
    output logic       inputs_enable,
    output logic       outputs_hiz,
    output logic       low_current,
    output logic       exit_window,
    output logic       entry_err,
    output logic       wake_err
);
    import snz_pkg::*;

    localparam int MAXD = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int CW   = $clog2(MAXD + 1);

    logic          req_s;
    logic          cnt_clr;
    logic [CW-1:0] cnt;
    state_e        state;

    snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sleep_req), .q(req_s)
    );

    snz_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .q(cnt)
    );

    snz_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .cmd(host_cmd),
        .cnt(cnt), .cnt_clr(cnt_clr), .state(state),
        .entry_err(entry_err), .wake_err(wake_err)
    );

    // Immediate effects of the raw pin plus state-driven deselect and status flags.
    assign outputs_hiz   = sleep_req;
    assign inputs_enable = !sleep_req;
    assign core_deselect = sleep_req || (state == ST_ENTER) || (state == ST_SLEEP);
    assign low_current   = (state == ST_SLEEP);
    assign exit_window   = (state == ST_EXIT);
endmodule

// File: rtl/sram_snooze_chk.sv
// Property checker for the snooze controller, attached to every instance by bind.
// Assumes the request is held at least one clock per level.
module sram_snooze_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic req_s,
    input logic core_deselect,
    input logic low_current,
    input logic exit_window,
    input logic entry_err,
    input logic wake_err
);
    AST_PIN_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> core_deselect);                                   // R3
    AST_LOW_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_current) |-> $past(req_s));                           // R4
    AST_EXIT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exit_window) |-> !$past(req_s));                          // R5
    AST_LOW_EXIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_current && exit_window));                                 // R6
    AST_WAKE_ERR_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        wake_err |-> $past(exit_window));                               // R7
    AST_ENTRY_ERR_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        entry_err |-> $past(!low_current && !exit_window));             // R8
    AST_ENTRY_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_err |=> !entry_err);                                      // R8
    AST_EXIT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_window && req_s) |=> !exit_window);                       // R9
endmodule

bind sram_snooze_ctrl sram_snooze_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .req_s(req_s),
    .core_deselect(core_deselect), .low_current(low_current),
    .exit_window(exit_window), .entry_err(entry_err), .wake_err(wake_err)
);

// File: tb/sram_snooze_ctrl_tb.sv
// Sweeps request hold lengths and every command at every cycle offset, with
// expected values derived from edge counts since the request rose.
module sram_snooze_ctrl_tb;
    localparam int E = 3;
    localparam int X = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [1:0] host_cmd = 2'd0;
    logic core_deselect, inputs_enable, outputs_hiz, low_current, exit_window, entry_err, wake_err;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sram_snooze_ctrl #(.ENTRY_CYC(E), .EXIT_CYC(X), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .host_cmd(host_cmd),
        .core_deselect(core_deselect), .inputs_enable(inputs_enable),
        .outputs_hiz(outputs_hiz), .low_current(low_current),
        .exit_window(exit_window), .entry_err(entry_err), .wake_err(wake_err)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    // One sleep episode: rise after edge 0, fall after edge h, cmd c held between edges inj and inj+1.
    task automatic episode(input int h, input int inj, input logic [1:0] c);
        sleep_req = 1'b1;
        #1;
        chk("R2", "hiz on rise", outputs_hiz, 1'b1);
        chk("R2", "inputs gated on rise", inputs_enable, 1'b0);
        chk("R3", "deselect on rise", core_deselect, 1'b1);
        host_cmd = (inj == 0) ? c : 2'd0;
        for (int t = 1; t <= h + X + 4; t++) begin
            step();
            chk("R4_R5_R10", "low_current", low_current, (t >= E + 3) && (t <= h + 2));
            chk("R6", "exit_window", exit_window, (t >= h + 3) && (t <= h + 2 + X));
            chk("R3", "core_deselect", core_deselect, sleep_req || ((t >= 3) && (t <= h + 2)));
            chk("R8", "entry_err", entry_err, (t == 3) && (inj == 2) && (c != 2'd0));
            chk("R7", "wake_err", wake_err,
                (t == inj + 1) && (inj >= h + 3) && (inj <= h + 2 + X) && (c >= 2'd2));
            if (t == h) sleep_req = 1'b0;
            host_cmd = (t == inj) ? c : 2'd0;
            #1;
            chk("R2", "outputs_hiz", outputs_hiz, sleep_req);
        end
        host_cmd = 2'd0;
        repeat (3) step();
    endtask

    initial begin
        repeat (3) step();
        chk("R1", "low_current in reset", low_current, 1'b0);
        chk("R1", "exit_window in reset", exit_window, 1'b0);
        chk("R1", "entry_err in reset", entry_err, 1'b0);
        chk("R1", "wake_err in reset", wake_err, 1'b0);
        chk("R2", "inputs_enable idle", inputs_enable, 1'b1);
        chk("R3", "deselect idle", core_deselect, 1'b0);
        rst_n = 1'b1;
        repeat (2) step();

        // R4 R5 R6 R10: hold lengths from shorter than the entry delay to well past it.
        for (int h = 1; h <= E + 5; h++) episode(h, -1, 2'd0);

        // R7 R8: every command code at every cycle offset of an episode.
        for (int c = 0; c < 4; c++)
            for (int inj = 0; inj <= E + 2 + X + 2; inj++)
                episode(E + 2, inj, 2'(c));

        // R9: re-raise the request during the exit window.
        begin
            int h = E + 3;
            int r = h + 4;
            sleep_req = 1'b1;
            for (int t = 1; t <= r + E + 5; t++) begin
                step();
                chk("R9", "exit_window abort", exit_window,
                    (t >= h + 3) && (t <= h + 2 + X) && (t <= r + 2));
                chk("R9", "low_current after abort", low_current,
                    ((t >= E + 3) && (t <= h + 2)) || (t >= r + 3 + E));
                chk("R9", "deselect after abort", core_deselect,
                    sleep_req || ((t >= 3) && (t <= h + 2)) || (t >= r + 3));
                if (t == h) sleep_req = 1'b0;
                if (t == r) sleep_req = 1'b1;
            end
            sleep_req = 1'b0;
            repeat (X + 6) step();
            chk("R9", "low_current after final exit", low_current, 1'b0);
            chk("R9", "exit_window after final exit", exit_window, 1'b0);
        end

        // R1: reset while asleep, with the pin still high.
        sleep_req = 1'b1;
        repeat (E + 5) step();
        chk("R1", "asleep before reset", low_current, 1'b1);
        rst_n = 1'b0;
        step();
        chk("R1", "low_current cleared", low_current, 1'b0);
        chk("R1", "exit_window cleared", exit_window, 1'b0);
        chk("R2", "hiz held by pin in reset", outputs_hiz, 1'b1);
        sleep_req = 1'b0;
        step();
        rst_n = 1'b1;
        for (int t = 0; t < 4; t++) begin
            step();
            chk("R1", "awake after reset", exit_window, 1'b0);
            chk("R1", "no sleep after reset", low_current, 1'b0);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule